// File: doc/BRIEF.md
# Packed-BCD Add/Subtract Arithmetic Unit

This unit is the add and subtract slice of an 8-bit accumulator datapath. It computes add-with-carry, subtract-with-borrow and an increment-the-operand-then-subtract operation. Each operation runs either in plain binary or in packed BCD, which stores two decimal digits per byte. It produces the result byte and four flags: negative, overflow, zero and carry. The flags follow one of two core flavours, chosen on each operation.

In the older flavour, decimal arithmetic takes its negative and overflow flags from the uncorrected intermediate sum. It takes its zero flag from the plain binary sum. In the newer flavour, negative and zero are taken again from the corrected result, and the unit raises a request for one extra bus cycle.

The sum logic is combinational. Its outputs are captured in one output register stage whenever the enable input is high. Results therefore appear one clock after the operands are presented. A build parameter can remove decimal support. In that build, every operation takes the binary path.

Top module: `bcd_alu`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: When `en_i` is high at a rising clock edge, all outputs take the values computed from that cycle's inputs. When `en_i` is low, every output keeps its previous value.
- R3: Binary add (`op_i` = 0, or `op_i` = 3, which behaves as add) computes S = acc + opnd + carry_in in 9 bits. The result is S[7:0] and the carry is S[8]. Overflow is set when the signed sum lies outside -128..127. Negative is result bit 7, and zero is set when the result is 0.
- R4: Binary subtract (`op_i` = 1) behaves as binary add with the operand bitwise inverted. Carry = 1 means no borrow occurred.
- R5: With `op_i` = 2, the operand is first incremented modulo 256 and then subtracted as for `op_i` = 1. `opnd_o` holds the incremented operand. For every other op, `opnd_o` holds the operand unchanged.
- R6: When `dec_i` is low, every op uses the binary path, whatever the values of the operands.
- R7: Decimal add of valid packed-BCD operands gives the BCD digits of (acc + opnd + carry_in) mod 100. The carry is set when that sum is 100 or more.
- R8: Decimal subtract of valid packed-BCD operands gives the BCD digits of (acc - opnd - (1 - carry_in)) mod 100. The carry is cleared exactly when the difference is negative.
- R9: Older flavour (`cmos_i` = 0), decimal mode: zero reflects the 8-bit binary sum or difference. Negative is bit 7 of the sum before the high-digit correction. For add, overflow uses that uncorrected sum. For subtract, overflow is the binary overflow. `extra_o` is 0.
- R10: Newer flavour (`cmos_i` = 1), decimal mode: negative and zero come from the final result, overflow is as in R9, and `extra_o` is 1. In every other case `extra_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Capture enable for the output register |
| op_i | input | 2 | 0 add, 1 subtract, 2 increment-then-subtract, 3 add |
| cmos_i | input | 1 | Flag flavour: 0 older, 1 newer |
| dec_i | input | 1 | Decimal mode flag |
| carry_i | input | 1 | Carry in (1 = no borrow for subtract) |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Memory operand |
| res_o | output | 8 | Result byte |
| neg_o | output | 1 | Negative flag |
| ovf_o | output | 1 | Overflow flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag |
| extra_o | output | 1 | Request for one extra bus cycle |
| opnd_o | output | 8 | Operand after any increment |

## Verification
There is no state beyond the single output register. A wrong sum, a wrong digit correction or a wrong flag source therefore shows at the ports one clock after the offending operands are presented.

The flavour quirks are easy to miss and only show for particular operands, so directed vectors target them:
- 0x50 + 0x50: older zero stays clear although the result is 0.
- 0x99 + 0x67: older zero sets although the result is nonzero.
- 0x00 - 0x01: the borrow wraps the result to 0x99.

Sweeps over valid BCD pairs cover ordinary digit correction in both flavours.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned DATA_W = 2 * NIB_W;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_INCS = 2'd2,
    OP_ADD2 = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              neg;
    logic              ovf;
    logic              zero;
    logic              carry;
  } alu_out_t;
endpackage

// File: rtl/alu_bin_path.sv
module alu_bin_path
  import bcd_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] m_i,
  input  logic              c_i,
  input  logic              sub_i,
  output alu_out_t          out_o
);
  logic [DATA_W-1:0] m_eff;
  logic [DATA_W:0]   sum;

  always_comb begin
    m_eff = sub_i ? ~m_i : m_i;
    sum   = {1'b0, a_i} + {1'b0, m_eff} + {{DATA_W{1'b0}}, c_i};
    out_o.res   = sum[DATA_W-1:0];
    out_o.carry = sum[DATA_W];
    out_o.neg   = sum[DATA_W-1];
    out_o.zero  = (sum[DATA_W-1:0] == '0);
    out_o.ovf   = ((sum[DATA_W-1] ^ a_i[DATA_W-1]) & (sum[DATA_W-1] ^ m_eff[DATA_W-1]));
  end
endmodule

// File: rtl/alu_dec_add.sv
module alu_dec_add
  import bcd_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] m_i,
  input  logic              c_i,
  output alu_out_t          out_o
);
  localparam logic [NIB_W:0]    LO_LIMIT = (NIB_W+1)'(10);
  localparam logic [NIB_W-1:0]  LO_FIX   = NIB_W'(6);
  localparam logic [DATA_W:0]   HI_LIMIT = (DATA_W+1)'(10) << NIB_W;
  localparam logic [DATA_W+1:0] HI_FIX   = (DATA_W+2)'(6) << NIB_W;

  logic [NIB_W:0]    lo_raw;
  logic [NIB_W:0]    lo_adj;
  logic [DATA_W:0]   hi_raw;
  logic [DATA_W+1:0] fin;
  logic [DATA_W-1:0] plain;

  always_comb begin
    lo_raw = {1'b0, a_i[NIB_W-1:0]} + {1'b0, m_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_i};
    if (lo_raw >= LO_LIMIT) lo_adj = {1'b1, lo_raw[NIB_W-1:0] + LO_FIX};
    else                    lo_adj = lo_raw;
    hi_raw = {1'b0, a_i[DATA_W-1:NIB_W], {NIB_W{1'b0}}}
           + {1'b0, m_i[DATA_W-1:NIB_W], {NIB_W{1'b0}}}
           + {{(DATA_W-NIB_W){1'b0}}, lo_adj};
    fin = {1'b0, hi_raw} + ((hi_raw >= HI_LIMIT) ? HI_FIX : '0);
    plain = a_i + m_i + {{(DATA_W-1){1'b0}}, c_i};
    out_o.res   = fin[DATA_W-1:0];
    out_o.carry = |fin[DATA_W+1:DATA_W];
    out_o.neg   = hi_raw[DATA_W-1];
    out_o.ovf   = (hi_raw[DATA_W-1] ^ a_i[DATA_W-1]) & (hi_raw[DATA_W-1] ^ m_i[DATA_W-1]);
    out_o.zero  = (plain == '0);
  end
endmodule

// File: rtl/alu_dec_sub.sv
module alu_dec_sub
  import bcd_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] m_i,
  input  logic              c_i,
  output alu_out_t          out_o
);
  localparam int unsigned WW = 2 * DATA_W;
  localparam logic [WW-1:0] LO_MAX  = WW'((1 << NIB_W) - 1);
  localparam logic [WW-1:0] LO_FIX  = WW'(6);
  localparam logic [WW-1:0] HI_MAX  = WW'((1 << DATA_W) - 1);
  localparam logic [WW-1:0] HI_FIX  = WW'(6) << NIB_W;
  localparam logic [WW-1:0] LO_MASK = LO_MAX;
  localparam logic [WW-1:0] HI_MASK = HI_MAX & ~LO_MAX;

  logic [WW-1:0] borrow;
  logic [WW-1:0] a_w, m_w;
  logic [WW-1:0] bin_diff;
  logic [WW-1:0] lo_d, lo_c, mid, fin;

  always_comb begin
    borrow   = {{(WW-1){1'b0}}, ~c_i};
    a_w      = {{DATA_W{1'b0}}, a_i};
    m_w      = {{DATA_W{1'b0}}, m_i};
    bin_diff = a_w - m_w - borrow;
    lo_d     = (a_w & LO_MASK) - (m_w & LO_MASK) - borrow;
    if (lo_d > LO_MAX) lo_d = lo_d - LO_FIX;
    lo_c     = (lo_d & LO_MASK) | ((lo_d > LO_MAX) ? ~LO_MASK : '0);
    mid      = lo_c + (a_w & HI_MASK) - (m_w & HI_MASK);
    fin      = (mid > HI_MAX) ? (mid - HI_FIX) : mid;
    out_o.res   = fin[DATA_W-1:0];
    out_o.carry = ~(fin > HI_MAX);
    out_o.neg   = mid[DATA_W-1];
    out_o.ovf   = (bin_diff[DATA_W-1] ^ a_i[DATA_W-1]) & (~bin_diff[DATA_W-1] ^ m_i[DATA_W-1]);
    out_o.zero  = (bin_diff[DATA_W-1:0] == '0);
  end
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
#(
  parameter bit DEC_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [1:0]        op_i,
  input  logic              cmos_i,
  input  logic              dec_i,
  input  logic              carry_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] res_o,
  output logic              neg_o,
  output logic              ovf_o,
  output logic              zero_o,
  output logic              carry_o,
  output logic              extra_o,
  output logic [DATA_W-1:0] opnd_o
);
  alu_op_e           op;
  logic              is_sub;
  logic [DATA_W-1:0] m_eff;
  logic              use_dec;
  alu_out_t          bin_out, dec_out, sel_out, nxt_out;
  logic              nxt_extra;

  always_comb begin
    op     = alu_op_e'(op_i);
    is_sub = (op == OP_SUB) || (op == OP_INCS);
    m_eff  = (op == OP_INCS) ? (opnd_i + {{(DATA_W-1){1'b0}}, 1'b1}) : opnd_i;
  end

  alu_bin_path u_bin (
    .a_i(acc_i), .m_i(m_eff), .c_i(carry_i), .sub_i(is_sub), .out_o(bin_out)
  );

  generate
    if (DEC_EN) begin : g_dec
      alu_out_t add_out, sub_out;
      alu_dec_add u_dadd (.a_i(acc_i), .m_i(m_eff), .c_i(carry_i), .out_o(add_out));
      alu_dec_sub u_dsub (.a_i(acc_i), .m_i(m_eff), .c_i(carry_i), .out_o(sub_out));
      assign dec_out = is_sub ? sub_out : add_out;
      assign use_dec = dec_i;
    end else begin : g_nodec
      assign dec_out = bin_out;
      assign use_dec = 1'b0;
    end
  endgenerate

  always_comb begin
    sel_out   = use_dec ? dec_out : bin_out;
    nxt_out   = sel_out;
    nxt_extra = 1'b0;
    if (use_dec && cmos_i) begin
      nxt_out.neg  = sel_out.res[DATA_W-1];
      nxt_out.zero = (sel_out.res == '0);
      nxt_extra    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o   <= '0;
      neg_o   <= 1'b0;
      ovf_o   <= 1'b0;
      zero_o  <= 1'b0;
      carry_o <= 1'b0;
      extra_o <= 1'b0;
      opnd_o  <= '0;
    end else if (en_i) begin
      res_o   <= nxt_out.res;
      neg_o   <= nxt_out.neg;
      ovf_o   <= nxt_out.ovf;
      zero_o  <= nxt_out.zero;
      carry_o <= nxt_out.carry;
      extra_o <= nxt_extra;
      opnd_o  <= m_eff;
    end
  end
endmodule

// File: rtl/bcd_alu_chk.sv
module bcd_alu_chk
  import bcd_alu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic [1:0]        op_i,
  input logic              cmos_i,
  input logic              dec_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic [DATA_W-1:0] res_o,
  input logic              neg_o,
  input logic              zero_o,
  input logic              extra_o,
  input logic [DATA_W-1:0] opnd_o
);
  // R2: no enable, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_i) |-> ($stable(res_o) && $stable(zero_o) && $stable(extra_o) && $stable(opnd_o)));

  // R10: extra cycle only for newer flavour in decimal mode
  p_extra_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i) |-> (extra_o == $past(cmos_i && dec_i)));

  // R10: newer flavour flags follow the final result
  p_cmos_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i && cmos_i) |-> ((zero_o == (res_o == '0)) && (neg_o == res_o[DATA_W-1])));

  // R6: binary path flags follow the result
  p_bin_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i && !dec_i) |-> ((zero_o == (res_o == '0)) && (neg_o == res_o[DATA_W-1])));

  // R5: operand output after increment-then-subtract
  p_inc_opnd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_i && (op_i == 2'd2)) |-> (opnd_o == DATA_W'($past(opnd_i) + 1)));
endmodule

bind bcd_alu bcd_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .cmos_i(cmos_i), .dec_i(dec_i),
  .opnd_i(opnd_i), .res_o(res_o), .neg_o(neg_o), .zero_o(zero_o), .extra_o(extra_o),
  .opnd_o(opnd_o)
);

// File: tb/sim_bcd_alu.sv
`timescale 1ns/1ps
module sim_bcd_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic       cmos_i = 1'b0, dec_i = 1'b0, carry_i = 1'b0;
  logic [7:0] acc_i = 8'd0, opnd_i = 8'd0;
  logic [7:0] res_o, opnd_o;
  logic       neg_o, ovf_o, zero_o, carry_o, extra_o;
  int         n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  bcd_alu u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input int op, input bit cm, input bit dc, input bit c,
                       input int a, input int m);
    @(negedge clk);
    op_i = op[1:0]; cmos_i = cm; dec_i = dc; carry_i = c;
    acc_i = a[7:0]; opnd_i = m[7:0]; en_i = 1'b1;
    @(negedge clk);
    en_i = 1'b0;
  endtask

  function automatic int to_bcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction
  function automatic int from_bcd(input int b);
    return (b >> 4) * 10 + (b & 15);
  endfunction

  // Reference binary computation from R3/R4/R5
  task automatic bin_case(input string tag, input int op, input bit cm, input bit c,
                          input int a, input int m);
    int mm, s, sa, sm, sres;
    mm = (op == 2) ? ((m + 1) % 256) : m;
    if (op == 1 || op == 2) mm = 255 - mm;
    s  = a + mm + c;
    sa = (a > 127) ? a - 256 : a;
    sm = (mm > 127) ? mm - 256 : mm;
    sres = sa + sm + c;
    apply(op, cm, 1'b0, c, a, m);
    chk({tag, " res"},   res_o,   s % 256);
    chk({tag, " carry"}, carry_o, s / 256);
    chk({tag, " ovf"},   ovf_o,   (sres > 127 || sres < -128) ? 1 : 0);
    chk({tag, " neg"},   neg_o,   ((s % 256) >= 128) ? 1 : 0);
    chk({tag, " zero"},  zero_o,  ((s % 256) == 0) ? 1 : 0);
    chk({tag, " extra"}, extra_o, 0);
  endtask

  task automatic t_reset;
    chk("R1 res",   res_o, 0);
    chk("R1 flags", {neg_o, ovf_o, zero_o, carry_o, extra_o}, 0);
    chk("R1 opnd",  opnd_o, 0);
  endtask

  task automatic t_binary;
    bin_case("R3 add", 0, 0, 0, 8'h7F, 8'h01);
    bin_case("R3 add carry", 0, 1, 1, 8'hFF, 8'h00);
    bin_case("R3 add op3", 3, 0, 0, 8'h80, 8'h80);
    bin_case("R4 sub", 1, 0, 1, 8'h50, 8'h30);
    bin_case("R4 sub borrow", 1, 1, 0, 8'h00, 8'h01);
    bin_case("R4 sub ovf", 1, 0, 1, 8'h80, 8'h01);
    for (int i = 0; i < 40; i++)
      bin_case("R6 sweep", i % 4, i[0], i[1], (i * 37) % 256, (i * 91 + 5) % 256);
  endtask

  task automatic t_inc;
    bin_case("R5 inc sub", 2, 0, 1, 8'h20, 8'h0F);
    chk("R5 opnd", opnd_o, 8'h10);
    bin_case("R5 inc wrap", 2, 0, 1, 8'h42, 8'hFF);
    chk("R5 opnd wrap", opnd_o, 8'h00);
    bin_case("R5 plain opnd", 1, 0, 1, 8'h42, 8'h33);
    chk("R5 opnd kept", opnd_o, 8'h33);
    apply(2, 0, 1, 1, 8'h10, 8'h04);
    chk("R5 dec inc res", res_o, 8'h05);
    chk("R5 dec inc carry", carry_o, 1);
  endtask

  task automatic t_hold;
    apply(0, 0, 0, 0, 8'h12, 8'h34);
    @(negedge clk);
    acc_i = 8'hFF; opnd_i = 8'hFF; dec_i = 1'b1; cmos_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 hold res", res_o, 8'h46);
    chk("R2 hold extra", extra_o, 0);
    chk("R2 hold opnd", opnd_o, 8'h34);
  endtask

  task automatic t_dec_sweep;
    for (int i = 0; i < 60; i++) begin
      int a, m, sum, dif;
      bit c, cm;
      a = (i * 7) % 100; m = (i * 13 + 3) % 100; c = i[0]; cm = i[1];
      sum = a + m + c;
      apply(0, cm, 1, c, to_bcd(a), to_bcd(m));
      chk("R7 res", res_o, to_bcd(sum % 100));
      chk("R7 carry", carry_o, (sum >= 100) ? 1 : 0);
      chk("R10 extra", extra_o, cm ? 1 : 0);
      if (cm) chk("R10 zero", zero_o, (res_o == 0) ? 1 : 0);
      dif = a - m - (c ? 0 : 1);
      apply(1, cm, 1, c, to_bcd(a), to_bcd(m));
      chk("R8 res", res_o, to_bcd((dif + 100) % 100));
      chk("R8 carry", carry_o, (dif >= 0) ? 1 : 0);
      if (cm) chk("R10 neg", neg_o, res_o[7]);
    end
    if (from_bcd(8'h99) != 99) chk("R7 helper", from_bcd(8'h99), 99);
  endtask

  task automatic t_flavours;
    // 0x99 + 0x01: result 00, carry
    apply(0, 0, 1, 0, 8'h99, 8'h01);
    chk("R9 res", res_o, 8'h00);
    chk("R9 carry", carry_o, 1);
    chk("R9 zero from binary", zero_o, 0);
    chk("R9 neg from raw", neg_o, 1);
    chk("R9 ovf", ovf_o, 0);
    chk("R9 extra", extra_o, 0);
    apply(0, 1, 1, 0, 8'h99, 8'h01);
    chk("R10 zero", zero_o, 1);
    chk("R10 neg", neg_o, 0);
    chk("R10 extra", extra_o, 1);
    // 0x50 + 0x50: result 00, overflow from raw sum A0
    apply(0, 0, 1, 0, 8'h50, 8'h50);
    chk("R9 res 50", res_o, 8'h00);
    chk("R9 zero 50", zero_o, 0);
    chk("R9 ovf 50", ovf_o, 1);
    chk("R9 neg 50", neg_o, 1);
    apply(0, 1, 1, 0, 8'h50, 8'h50);
    chk("R10 zero 50", zero_o, 1);
    chk("R10 ovf 50", ovf_o, 1);
    // 0x99 + 0x67: binary low byte 00, BCD result 66
    apply(0, 0, 1, 0, 8'h99, 8'h67);
    chk("R9 res 66", res_o, 8'h66);
    chk("R9 zero binary", zero_o, 1);
    chk("R9 neg 66", neg_o, 0);
    apply(0, 1, 1, 0, 8'h99, 8'h67);
    chk("R10 zero 66", zero_o, 0);
    // 0x00 - 0x01: wraps to 99 with borrow
    apply(1, 0, 1, 1, 8'h00, 8'h01);
    chk("R8 res wrap", res_o, 8'h99);
    chk("R8 carry wrap", carry_o, 0);
    chk("R9 neg sub", neg_o, 1);
    chk("R9 zero sub", zero_o, 0);
    chk("R9 ovf sub", ovf_o, 0);
    // decimal flag clear: same operands use binary
    apply(0, 1, 0, 0, 8'h99, 8'h01);
    chk("R6 bin res", res_o, 8'h9A);
    chk("R6 bin extra", extra_o, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_binary;
    t_inc;
    t_hold;
    t_dec_sweep;
    t_flavours;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule